// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block sits on the processor side of an external memory bus where one 16-bit set of wires carries both the address and the data. Each access takes one instruction cycle of four clocks (phases Q1 to Q4). In Q1 the address goes out with a latch strobe high, so that external latches can hold it. Q2 turns the bus around. Q3 and Q4 carry the data: read data comes in under output enable, or write data goes out under the write strobe.

Requests are single-cycle pulses that carry a direction, an address, write data and an internal-target flag. A request arriving mid-cycle is held in a one-entry slot until the next Q1. A two-bit mode selects the bus behaviour:
- In internal-only mode the bus stays quiet and reads come from the internal memory port.
- In processor mode every access goes to the external bus.
- In extended mode an access flagged internal still runs the full strobe sequence on the bus, but its read result comes from the internal port and the external data is discarded.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the phase is Q1 with no access active: adOe=0, ale=0, oeN=1, wrN=1, done=0, rdata=0.
- R2: A request pulse is captured at the clock edge that ends the next Q4 (a pulse present during Q4 is captured at that very edge). The access then occupies the following four cycles Q1..Q4. A request issued while another access is active waits in a holding slot and starts in the Q1 directly after that access, giving one access per instruction cycle.
- R3: In Q1 of a bus-visible access the controller drives the latched address on adOut with adOe=1 and ale=1. ale is 0 in every other cycle.
- R4: A read releases the bus (adOe=0) in Q2..Q4 and holds oeN=0 in Q3 and Q4. wrN stays 1 throughout. rdata takes the read value at the edge ending Q4.
- R5: A write drives the write data on adOut with adOe=1 in Q3 and Q4, pulls wrN=0 in Q3 only, and keeps oeN=1. A write leaves rdata unchanged.
- R6: done is high for exactly one cycle: the Q1 that follows the access's Q4. It is low at all other times.
- R7: In extended mode (busMode 2'b10 or 2'b11), a request with reqInternal=1 shows the same strobe and bus sequence as an external access. Its read result comes from intRdata, and adIn is ignored.
- R8: In internal-only mode (busMode 2'b00), adOe=0, ale=0, oeN=1 and wrN=1 at all times, and reads return intRdata. In processor mode (busMode 2'b01), reqInternal is ignored and every read returns adIn.
- R9: The controller never drives the bus (adOe=1) while oeN=0. The bus is released in every cycle with no active access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| busMode | input | 2 | 00 internal-only, 01 processor, 1x extended; sampled at capture |
| reqValid | input | 1 | Single-cycle request pulse |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqInternal | input | 1 | Access targets internal memory (extended mode only) |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data |
| intRdata | input | 16 | Read data from internal memory |
| adIn | input | 16 | Value seen on the shared bus pins |
| adOut | output | 16 | Value driven onto the shared bus |
| adOe | output | 1 | Bus output enable, 1 = controller drives |
| ale | output | 1 | Address-latch strobe, active high |
| oeN | output | 1 | Output-enable strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| done | output | 1 | Access-complete pulse |
| rdata | output | 16 | Last read result |

## Verification
The bench counts cycles from reset. From the cycle in which it pulses a request, it computes the first Q1 of that access as the cycle after the next phase-Q4 cycle. The four strobes and the bus are then due in that Q1 and the three cycles after it, and done and rdata are due four cycles after that Q1. Every output is compared once per cycle at the falling edge against an expected-access queue, so a strobe or result that is one cycle early or late shows up as a mismatch in a specific cycle. Back-to-back requests, a pulse issued during Q4, and requests in each mode place these windows next to each other and at their edges.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_t;

  localparam logic [1:0] MODE_INTERNAL = 2'b00;
  localparam logic [1:0] MODE_PROC     = 2'b01;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic loadPend;    // store incoming request in holding slot
    logic loadAct;     // move request into active registers
    logic actFromReq;  // active source is the incoming request
    logic driveBus;    // enable bus drivers
    logic selData;     // 1: write data on bus, 0: address
    logic captureRd;   // latch read result
    logic rdFromInt;   // read result from internal port
  } strobe_t;
endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busMode,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqInternal,
  output strobe_t    strb,
  output logic       ale,
  output logic       oeN,
  output logic       wrN,
  output logic       done
);
  phase_t phase;
  logic   pendValid, pendWrite, pendInt;
  logic   actValid, actWrite, actShown, actInt;
  logic   isQ4, dataPhase, visible;
  logic   nextWrite, nextInt;

  assign isQ4      = (phase == PH_Q4);
  assign dataPhase = (phase == PH_Q3) || (phase == PH_Q4);
  assign nextWrite = reqValid ? reqWrite : pendWrite;
  assign nextInt   = reqValid ? reqInternal : pendInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_Q1;
      pendValid <= 1'b0;
      pendWrite <= 1'b0;
      pendInt   <= 1'b0;
      actValid  <= 1'b0;
      actWrite  <= 1'b0;
      actShown  <= 1'b0;
      actInt    <= 1'b0;
      done      <= 1'b0;
    end else begin
      phase <= phase_t'(phase + 2'd1);
      done  <= actValid && isQ4;
      if (isQ4) begin
        actValid  <= reqValid || pendValid;
        actWrite  <= nextWrite;
        actShown  <= (busMode != MODE_INTERNAL);
        actInt    <= (busMode == MODE_INTERNAL) || (busMode[1] && nextInt);
        pendValid <= 1'b0;
      end else if (reqValid) begin
        pendValid <= 1'b1;
        pendWrite <= reqWrite;
        pendInt   <= reqInternal;
      end
    end
  end

  assign visible = actValid && actShown;

  always_comb begin
    strb.loadPend   = reqValid && !isQ4;
    strb.loadAct    = isQ4;
    strb.actFromReq = reqValid;
    strb.driveBus   = visible && ((phase == PH_Q1) || (actWrite && dataPhase));
    strb.selData    = (phase != PH_Q1);
    strb.captureRd  = actValid && !actWrite && isQ4;
    strb.rdFromInt  = actInt;
    ale = visible && (phase == PH_Q1);
    oeN = !(visible && !actWrite && dataPhase);
    wrN = !(visible && actWrite && (phase == PH_Q3));
  end

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.driveBus && !oeN));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r3_ale_in_q1: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (phase == PH_Q2));
  a_r5_wr_with_drive: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (strb.driveBus && oeN));
  a_r4_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> wrN);
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    isQ4 |=> (phase == PH_Q1));
endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [BUS_W-1:0] intRdata,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] pendAddr, pendWdata, actAddr, actWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendWdata <= '0;
      actAddr   <= '0;
      actWdata  <= '0;
      rdata     <= '0;
    end else begin
      if (strb.loadPend) begin
        pendAddr  <= reqAddr;
        pendWdata <= reqWdata;
      end
      if (strb.loadAct) begin
        actAddr  <= strb.actFromReq ? reqAddr  : pendAddr;
        actWdata <= strb.actFromReq ? reqWdata : pendWdata;
      end
      if (strb.captureRd)
        rdata <= strb.rdFromInt ? intRdata : adIn;
    end
  end

  assign adOut = strb.selData ? actWdata : actAddr;
  assign adOe  = strb.driveBus;

  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureRd |=> $stable(rdata));
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busMode,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqInternal,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [BUS_W-1:0] intRdata,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  output logic             ale,
  output logic             oeN,
  output logic             wrN,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  strobe_t strb;

  mbc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqInternal(reqInternal), .strb(strb),
    .ale(ale), .oeN(oeN), .wrN(wrN), .done(done)
  );

  mbc_datapath #(.BUS_W(BUS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .intRdata(intRdata), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .rdata(rdata)
  );
endmodule

// File: tb/mux_bus_ctrl_test.sv
module mux_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busMode = 2'b01;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqInternal = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, intRdata = 16'h0F0F;
  logic [15:0] adIn, adOut, rdata;
  logic        adOe, ale, oeN, wrN, done;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] latchAddr = '0, modelRd = '0;
  bit finished = 0;

  typedef struct {
    int start; bit write; bit shown; bit fromInt;
    logic [15:0] addr; logic [15:0] wdata; logic [15:0] expRd;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  mux_bus_ctrl uut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqInternal(reqInternal), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .intRdata(intRdata), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .ale(ale), .oeN(oeN), .wrN(wrN), .done(done), .rdata(rdata)
  );

  function automatic logic [15:0] extVal(logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  // External memory: answers only under output enable.
  assign adIn = !oeN ? extVal(latchAddr) : 16'hBEEF;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic issue(input bit w, input bit intl, input logic [15:0] a,
                       input logic [15:0] d);
    item_t it;
    it.start   = cyc + (3 - cyc % 4) + 1;
    it.write   = w;
    it.shown   = (busMode != 2'b00);
    it.fromInt = (busMode == 2'b00) || (busMode[1] && intl);
    it.addr    = a;
    it.wdata   = d;
    if (!w) modelRd = it.fromInt ? intRdata : extVal(a);
    it.expRd   = modelRd;
    q.push_back(it);
    reqValid = 1'b1; reqWrite = w; reqInternal = intl; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqInternal = 1'b0;
  endtask

  task automatic waitPhase(input int ph);
    while (cyc % 4 != ph) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: per-cycle comparison against the expected-access queue.
  always @(negedge clk) begin
    if (rstN) begin
      bit act, expAle, expOe, expOeN, expWrN;
      int ph;
      string tag;
      ph = cyc % 4;
      if (q.size() > 0 && cyc == q[0].start + 4) begin
        chk(done == 1'b1, "R6", "done pulse", done, 1);
        tag = q[0].write ? "R5" : (!q[0].shown || (q[0].fromInt && busMode == 2'b00)) ? "R8"
              : q[0].fromInt ? "R7" : "R4";
        chk(rdata == q[0].expRd, tag, "rdata", rdata, q[0].expRd);
        void'(q.pop_front());
      end else begin
        chk(done == 1'b0, "R6", "done idle", done, 0);
      end
      act = (q.size() > 0) && (cyc >= q[0].start) && (cyc < q[0].start + 4);
      if (act && q[0].shown) begin
        expAle = (ph == 0);
        expOe  = (ph == 0) || (q[0].write && ph >= 2);
        expOeN = !(!q[0].write && ph >= 2);
        expWrN = !(q[0].write && ph == 2);
        chk(ale == expAle, "R3", "ale", ale, expAle);
        chk(adOe == expOe, q[0].write ? "R5" : "R4", "adOe", adOe, expOe);
        chk(oeN == expOeN, "R4", "oeN", oeN, expOeN);
        chk(wrN == expWrN, "R5", "wrN", wrN, expWrN);
        if (ph == 0) chk(adOut == q[0].addr, "R3", "address", adOut, q[0].addr);
        if (q[0].write && ph >= 2) chk(adOut == q[0].wdata, "R5", "write data", adOut, q[0].wdata);
      end else begin
        tag = act ? "R8" : "R9";
        chk(ale == 1'b0 && adOe == 1'b0 && oeN && wrN, tag, "quiet bus",
            {ale, adOe, oeN, wrN}, 4'b0011);
      end
      chk(!(adOe && !oeN), "R9", "contention", {adOe, oeN}, 2'b01);
      if (ale) latchAddr = adOut;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(adOe == 0 && ale == 0 && oeN && wrN && done == 0 && rdata == 0, "R1",
        "reset outputs", {adOe, ale, oeN, wrN, done}, 5'b00110);
    rstN = 1'b1;
    @(negedge clk);
    // Processor mode: external read/write, reqInternal ignored (R8).
    busMode = 2'b01;
    waitPhase(1); issue(0, 0, 16'h1234, 16'h0);          // R2 mid-cycle wait, R4
    waitIdle();
    waitPhase(2); issue(1, 0, 16'h4321, 16'hCAFE);       // R5
    waitIdle();
    waitPhase(0); issue(0, 1, 16'h0A0A, 16'h0);          // R8 reqInternal ignored
    waitIdle();
    // Extended mode (R7).
    busMode = 2'b10;
    waitPhase(1); issue(0, 1, 16'h2222, 16'h0);
    waitIdle();
    waitPhase(1); issue(0, 0, 16'h3333, 16'h0);
    waitIdle();
    waitPhase(1); issue(1, 1, 16'h4444, 16'h1357);
    waitIdle();
    busMode = 2'b11; intRdata = 16'h7E81;
    waitPhase(2); issue(0, 1, 16'h5555, 16'h0);
    waitIdle();
    // Internal-only mode (R8).
    busMode = 2'b00; intRdata = 16'h9669;
    waitPhase(1); issue(0, 0, 16'h6666, 16'h0);
    waitIdle();
    waitPhase(1); issue(1, 0, 16'h7777, 16'hAAAA);
    waitIdle();
    // Back-to-back in processor mode: Q4 capture then holding slot (R2).
    busMode = 2'b01;
    waitPhase(3); issue(0, 0, 16'h8001, 16'h0);
    waitPhase(1); issue(1, 0, 16'h8002, 16'h55AA);
    waitPhase(1); issue(0, 0, 16'h8003, 16'h0);
    waitIdle();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule